// File: doc/BRIEF.md
# Continuous-Phase Two-Tone FSK Generator

This block synthesises the transmit tone of a low-speed frequency-shift-keyed line modem. A single data bit picks one of two tones. The tone pair comes from three selects: the standard (V.21 or V.23), the role (originate or answer, used by V.21), and the channel (main or back, used by V.23). A 24-bit phase accumulator advances once per sample-rate enable. Its top bits address a computed one-period waveform table, and that table drives a signed sample output.

The data bit steers the tone directly. It passes through no scrambler and no rate converter, so a new bit changes the tone on the very next sample. Switching tones replaces only the phase increment. The accumulator keeps its value, so the waveform never jumps in phase. While transmit is disabled, the block sends the mark tone of the selected pair.

Top module: `fsk_tone_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the phase accumulator and `sample_out` are cleared to zero after that edge.
- R2: With `std_sel`=0 and `role`=0 (V.21 originate), mark (`data_bit`=1) is 980 Hz and space (`data_bit`=0) is 1180 Hz. `chan` has no effect in V.21.
- R3: With `std_sel`=0 and `role`=1 (V.21 answer), mark is 1650 Hz and space is 1850 Hz.
- R4: With `std_sel`=1 and `chan`=0 (V.23 main channel), mark is 1300 Hz and space is 2100 Hz. `role` has no effect in V.23.
- R5: With `std_sel`=1 and `chan`=1 (V.23 back channel), mark is 390 Hz and space is 450 Hz.
- R6: While `tx_en`=0, the mark tone of the selected pair is produced whatever `data_bit` is.
- R7: The accumulator and `sample_out` change only on an edge where `sample_en`=1. On such an edge the accumulator adds round(f·2^24/9600), and `sample_out` takes the waveform value of the phase held before the add.
- R8: A tone change alters only the increment, never the accumulator. The selects and `data_bit` present at a sampling edge set the step of that edge, with no scrambling or rate conversion in between.
- R9: The waveform is addressed by accumulator bits [23:16]. It is zero at addresses 0 and 128, positive over 1..127 and negative over 129..255. Its magnitude never exceeds 2047, and it reaches 2047 at address 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe at the sample rate (9600 Hz) |
| tx_en | input | 1 | 1 = send data tones, 0 = idle on mark |
| data_bit | input | 1 | 1 = mark, 0 = space |
| std_sel | input | 1 | 0 = V.21, 1 = V.23 |
| role | input | 1 | 0 = originate, 1 = answer (V.21) |
| chan | input | 1 | 0 = main, 1 = back channel (V.23) |
| sample_out | output | 12 | Signed waveform sample |

## Verification
A sampling edge puts out the waveform of the phase held before that edge. The selects seen at the same edge shape the step, so a tone change first shows in the sample one strobe later. The bench drives every input on a falling edge and raises `sample_en` for one clock. It reads `sample_out` at the next falling edge and compares it with its own accumulator model, which has been advanced by the same one-strobe lag. Each frequency is measured by counting zero crossings over 4800 samples (half a second), which gives f crossings within ±1%.

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int ACC_W     = 24,
  parameter int LUT_AW    = 8,
  parameter int OUT_W     = 12,
  parameter int SAMPLE_HZ = 9600
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_en,
  input  logic                    tx_en,
  input  logic                    data_bit,
  input  logic                    std_sel,
  input  logic                    role,
  input  logic                    chan,
  output logic signed [OUT_W-1:0] sample_out
);
  localparam int LUT_N = 2 ** LUT_AW;
  localparam int HALF  = LUT_N / 2;
  localparam int AMP   = 2 ** (OUT_W - 1) - 1;

  function automatic int tone_hz(input logic v23, input logic ans, input logic back, input logic mark);
    if (v23) begin
      if (back) return mark ? 390 : 450;
      return mark ? 1300 : 2100;
    end
    if (ans) return mark ? 1650 : 1850;
    return mark ? 980 : 1180;
  endfunction

  function automatic logic [ACC_W-1:0] step_of(input int hz);
    logic [63:0] num;
    num = (64'(hz) << ACC_W) + 64'(SAMPLE_HZ / 2);
    return ACC_W'(num / 64'(SAMPLE_HZ));
  endfunction

  function automatic logic signed [OUT_W-1:0] shape(input int addr);
    logic [63:0] x, mag;
    x   = 64'(addr % HALF);
    mag = (64'd4 * x * (64'(HALF) - x) * 64'(AMP)) / (64'(HALF) * 64'(HALF));
    return (addr >= HALF) ? -$signed(OUT_W'(mag)) : $signed(OUT_W'(mag));
  endfunction

  logic [ACC_W-1:0]        step_tab [16];
  logic signed [OUT_W-1:0] wave_rom [LUT_N];

  for (genvar k = 0; k < 16; k++) begin : g_step
    localparam logic [3:0] KEY = 4'(k);
    assign step_tab[k] = step_of(tone_hz(KEY[3], KEY[2], KEY[1], KEY[0]));
  end

  for (genvar a = 0; a < LUT_N; a++) begin : g_wave
    assign wave_rom[a] = shape(a);
  end

  logic             mark;
  logic [ACC_W-1:0] phase_acc;
  logic [ACC_W-1:0] phase_inc;

  assign mark      = data_bit | ~tx_en;
  assign phase_inc = step_tab[{std_sel, role, chan, mark}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_acc  <= '0;
      sample_out <= '0;
    end else if (sample_en) begin
      phase_acc  <= phase_acc + phase_inc;
      sample_out <= wave_rom[phase_acc[ACC_W-1 -: LUT_AW]];
    end
  end
endmodule

module fsk_tone_gen_chk #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_en,
  input logic                    tx_en,
  input logic                    data_bit,
  input logic                    std_sel,
  input logic                    role,
  input logic                    chan,
  input logic [ACC_W-1:0]        phase_acc,
  input logic [ACC_W-1:0]        phase_inc,
  input logic signed [OUT_W-1:0] sample_out
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (phase_acc == '0 && sample_out == '0));

  assert_v21_chan_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!std_sel && $stable(std_sel) && $stable(role) && $stable(tx_en) && $stable(data_bit))
      |-> $stable(phase_inc));

  assert_v23_role_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (std_sel && $stable(std_sel) && $stable(chan) && $stable(tx_en) && $stable(data_bit))
      |-> $stable(phase_inc));

  assert_idle_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && $past(!tx_en) && $stable(std_sel) && $stable(role) && $stable(chan))
      |-> $stable(phase_inc));

  assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(phase_acc) && $stable(sample_out)));

  assert_no_phase_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && phase_inc != '0) |=> (phase_acc != $past(phase_acc)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_out != {1'b1, {(OUT_W-1){1'b0}}});
endmodule

bind fsk_tone_gen fsk_tone_gen_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tx_en(tx_en),
  .data_bit(data_bit), .std_sel(std_sel), .role(role), .chan(chan),
  .phase_acc(phase_acc), .phase_inc(phase_inc), .sample_out(sample_out)
);

// File: tb/tb_fsk_tone_gen.sv
module tb_fsk_tone_gen;
  logic clk = 0;
  logic rst_n = 0;
  logic sample_en = 0, tx_en = 0, data_bit = 1, std_sel = 0, role = 0, chan = 0;
  logic signed [11:0] sample_out;

  fsk_tone_gen dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tx_en(tx_en),
    .data_bit(data_bit), .std_sel(std_sel), .role(role), .chan(chan),
    .sample_out(sample_out)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [23:0] model_ph = '0;
  int model_err = 0, last_sign = 0, crossings = 0, peak_hi = 0, peak_lo = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_hz(input bit v23, input bit ans, input bit back, input bit bitv, input bit en);
    bit mk;
    mk = bitv | !en;
    if (v23) return back ? (mk ? 390 : 450) : (mk ? 1300 : 2100);
    return ans ? (mk ? 1650 : 1850) : (mk ? 980 : 1180);
  endfunction

  function automatic logic [23:0] inc_of(input int hz);
    longint num;
    num = (longint'(hz) * 64'd16777216 + 4800) / 9600;
    return 24'(num);
  endfunction

  // One strobe; output shows waveform of model phase before the add (R7, R8, R9)
  task automatic do_sample();
    logic [7:0] a;
    int s;
    @(negedge clk) sample_en = 1;
    @(negedge clk) sample_en = 0;
    a = model_ph[23:16];
    if (a[6:0] == 0) begin
      if (sample_out != 0) model_err++;
    end else if (!a[7]) begin
      if (sample_out <= 0) model_err++;
    end else begin
      if (sample_out >= 0) model_err++;
    end
    model_ph = model_ph + inc_of(exp_hz(std_sel, role, chan, data_bit, tx_en));
    s = (sample_out > 0) ? 1 : ((sample_out < 0) ? -1 : 0);
    if (s != 0) begin
      if (last_sign != 0 && s != last_sign) crossings++;
      last_sign = s;
    end
    if (int'(sample_out) > peak_hi) peak_hi = int'(sample_out);
    if (int'(sample_out) < peak_lo) peak_lo = int'(sample_out);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(sample_out == 0, "R1 output cleared in reset", int'(sample_out), 0);
    rst_n = 1;
    model_ph = '0;
    do_sample();
    check(sample_out == 0 && model_err == 0, "R1 first sample from zero phase", int'(sample_out), 0);
  endtask

  task automatic t_tone(input bit v23, input bit ans, input bit back, input bit bitv,
                        input bit en, input int hz, input string req);
    int diff;
    @(negedge clk);
    std_sel = v23; role = ans; chan = back; data_bit = bitv; tx_en = en;
    do_sample();
    crossings = 0; last_sign = 0; model_err = 0;
    for (int i = 0; i < 4800; i++) do_sample();
    diff = crossings - hz;
    if (diff < 0) diff = -diff;
    check(diff * 100 <= hz + 100, req, crossings, hz);
    check(model_err == 0, {req, " / R8 phase track"}, model_err, 0);
  endtask

  task automatic t_hold();
    logic signed [11:0] held;
    do_sample();
    held = sample_out;
    repeat (20) @(negedge clk);
    check(sample_out == held, "R7 output holds without strobe", int'(sample_out), int'(held));
    do_sample();
    check(model_err == 0, "R7 accumulator held without strobe", model_err, 0);
  endtask

  task automatic t_switch();
    model_err = 0;
    std_sel = 0; role = 0; chan = 0; tx_en = 1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk) data_bit = ((i % 3) == 0);
      if ((i % 7) == 0) begin std_sel = ~std_sel; chan = ~chan; end
      do_sample();
    end
    check(model_err == 0, "R8 continuous phase over bit and mode changes", model_err, 0);
  endtask

  task automatic t_peak();
    peak_hi = 0; peak_lo = 0;
    t_tone(1, 0, 1, 1, 1, 390, "R5 peak window 390 Hz");
    check(peak_hi <= 2047 && peak_hi >= 2000, "R9 positive peak", peak_hi, 2047);
    check(peak_lo >= -2047 && peak_lo <= -2000, "R9 negative peak", peak_lo, -2047);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_tone(0, 0, 0, 1, 1, 980,  "R2 V.21 orig mark");
        t_tone(0, 0, 0, 0, 1, 1180, "R2 V.21 orig space");
        t_tone(0, 0, 1, 0, 1, 1180, "R2 V.21 chan ignored");
        t_tone(0, 1, 0, 1, 1, 1650, "R3 V.21 answer mark");
        t_tone(0, 1, 0, 0, 1, 1850, "R3 V.21 answer space");
        t_tone(1, 0, 0, 1, 1, 1300, "R4 V.23 main mark");
        t_tone(1, 1, 0, 0, 1, 2100, "R4 V.23 main space, role ignored");
        t_tone(1, 0, 1, 0, 1, 450,  "R5 V.23 back space");
        t_tone(0, 1, 0, 0, 0, 1650, "R6 idle sends mark");
        t_hold();
        t_switch();
        t_peak();
        done = 1;
      end
      begin
        repeat (190000) @(negedge clk);
        if (!done) check(0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule